// File: doc/BRIEF.md
# Cluster Performance Monitor Counter Bank

This block collects usage statistics for a shared multi-core cluster. It holds a parameterised number of independent 32-bit event counters and one 64-bit cycle counter. Each event counter is programmed with an event code that picks one line of an incoming vector of single-cycle event strobes. While the counter is enabled, it adds one for every cycle in which that strobe is high. Counting covers the whole cluster. There is no per-process filtering and no sampling mode.

Software reaches the block through a flat register port that writes in one cycle and reads combinationally. Enable, overflow and interrupt-enable state are each held in a 32-bit status word. Bit n of that word is event counter n, and bit 31 is the cycle counter. Each word has a write-one-to-set register and a write-one-to-clear register. Event type and event count are not mapped directly: they act on whichever counter a selector register names. Two read-only identification words show which event codes are implemented. A single level interrupt goes high while any overflow flag is set and its interrupt enable is also set.

Top module: `clust_pmu`

## Requirements
- R1: After reset, every counter, every status word, the selector and the global enable are zero, and `irq` is low.
- R2: Event counter n adds one at the clock edge that ends a cycle in which all of these hold: the strobe line named by its event code is high, enable bit n is set, and the global enable is set. Otherwise it holds its value. An event code of NUM_EVT or more never counts.
- R3: A write to EN_SET (address 1) sets every enable bit where the data is 1. A write to EN_CLR (address 2) clears every enable bit where the data is 1. Data bits that are 0 change nothing. Reading either address returns the enable word. Bit 31 is the cycle counter.
- R4: When an enabled counter steps from all ones to zero, its overflow flag is set. Event counter n sets flag n, and the 64-bit cycle counter sets flag 31.
- R5: Reading OVF_CLR (address 4) returns the overflow word. Writing 1s there clears those flags, and writing 1s to OVF_SET (address 3) sets them. If a wrap and a clear of the same flag fall in the same cycle, the flag ends up set.
- R6: IE_SET (address 5) and IE_CLR (address 6) set and clear interrupt-enable bits in the same way as R3. `irq` is high exactly when some overflow flag and its interrupt enable are both set.
- R7: SEL (address 7) holds a counter index. EVTYPE (address 8) and EVCNT (address 9) read and write the event code and the count of the selected counter. If the index is NUM_CNT or more, both registers read as zero and writes to them have no effect.
- R8: A write to EVCNT in a cycle where the selected counter would also count loads the written value, and that cycle's increment is lost.
- R9: CYC_LO (address 10) and CYC_HI (address 11) read and write the two halves of the cycle counter. The counter adds one every cycle while bit 31 of the enable word and the global enable are both set.
- R10: CTRL (address 0) bit 0 is the global enable. Writing 1 to bit 1 zeroes all event counters, and writing 1 to bit 2 zeroes the cycle counter. These zeroing actions win over a count in the same cycle. Bits 1 and 2 always read as 0.
- R11: ID0 (address 12) bit k is set exactly when event code k is below NUM_EVT. ID1 (address 13) bit k does the same for code 32+k. Writes to either register are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe for the current cycle |
| addr | input | ADDR_W | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| evt_strobe | input | NUM_EVT | Event strobes, one line per implemented event code |
| irq | output | 1 | Level, active-high overflow interrupt |

## Verification
Several functions can act on the same state in the same cycle. The two that matter most are a counter wrapping and a software write to the overflow-clear register for that same flag. The bench brings a counter to all ones, sets its flag by software, and then writes the clear in the very cycle the strobe makes the counter wrap. The flag must survive. The same approach is used for an EVCNT load against an increment, and for the zeroing bits in CTRL against an increment. In every case a behavioural model predicts the winner, and the count or flag is read back through the register port one cycle later.

// File: rtl/clust_pmu_pkg.sv
package clust_pmu_pkg;

    // Register addresses; the bench and software rely on these values.
    typedef enum logic [3:0] {
        RA_CTRL    = 4'd0,
        RA_EN_SET  = 4'd1,
        RA_EN_CLR  = 4'd2,
        RA_OVF_SET = 4'd3,
        RA_OVF_CLR = 4'd4,
        RA_IE_SET  = 4'd5,
        RA_IE_CLR  = 4'd6,
        RA_SEL     = 4'd7,
        RA_EVTYPE  = 4'd8,
        RA_EVCNT   = 4'd9,
        RA_CYC_LO  = 4'd10,
        RA_CYC_HI  = 4'd11,
        RA_ID0     = 4'd12,
        RA_ID1     = 4'd13
    } pmu_reg_e;

    localparam int CYC_BIT    = 31; // status bit owned by the cycle counter
    localparam int CTRL_GEN   = 0;  // global enable
    localparam int CTRL_ZEVT  = 1;  // zero event counters
    localparam int CTRL_ZCYC  = 2;  // zero cycle counter
    localparam int SEL_W      = 5;

endpackage

// File: rtl/pmu_evt_cnt.sv
module pmu_evt_cnt #(
    parameter int NUM_EVT = 16,
    parameter int EVT_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               count_en,
    input  logic               zero,
    input  logic               wr_type,
    input  logic               wr_cnt,
    input  logic [31:0]        wdata,
    input  logic [NUM_EVT-1:0] evt_strobe,
    output logic [31:0]        cnt_o,
    output logic [EVT_W-1:0]   type_o,
    output logic               wrap_o
);
    localparam int IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
    localparam logic [EVT_W:0] CODE_LIM = (EVT_W+1)'(NUM_EVT);

    typedef struct packed {
        logic [31:0]      cnt;
        logic [EVT_W-1:0] code;
    } evt_state_t;

    evt_state_t st_d, st_q;
    logic       hit;

    always_comb begin
        st_d   = st_q;
        hit    = 1'b0;
        if (count_en && ({1'b0, st_q.code} < CODE_LIM))
            hit = evt_strobe[st_q.code[IDX_W-1:0]];
        wrap_o = 1'b0;
        if (zero) begin
            st_d.cnt = '0;
        end else if (wr_cnt) begin
            st_d.cnt = wdata;
        end else if (hit) begin
            st_d.cnt = st_q.cnt + 32'd1;
            wrap_o   = (st_q.cnt == '1);
        end
        if (wr_type)
            st_d.code = wdata[EVT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign type_o = st_q.code;

endmodule

// File: rtl/pmu_cyc_cnt.sv
module pmu_cyc_cnt (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        count_en,
    input  logic        zero,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    output logic [63:0] cnt_o,
    output logic        wrap_o
);
    logic [63:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        wrap_o = 1'b0;
        if (zero) begin
            cnt_d = '0;
        end else if (wr_lo) begin
            cnt_d[31:0] = wdata;
        end else if (wr_hi) begin
            cnt_d[63:32] = wdata;
        end else if (count_en) begin
            cnt_d  = cnt_q + 64'd1;
            wrap_o = (cnt_q == '1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/clust_pmu.sv
module clust_pmu
    import clust_pmu_pkg::*;
#(
    parameter int NUM_CNT = 4,   // 2..30
    parameter int NUM_EVT = 16,  // 1..64
    parameter int EVT_W   = 6,
    parameter int ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    input  logic [NUM_EVT-1:0] evt_strobe,
    output logic               irq
);
    localparam int IDX_W = $clog2(NUM_CNT);
    localparam logic [SEL_W-1:0] SEL_LIM = SEL_W'(NUM_CNT);
    localparam logic [31:0] LIVE_MASK =
        {1'b1, {(31-NUM_CNT){1'b0}}, {NUM_CNT{1'b1}}};

    typedef struct packed {
        logic             gen_en;
        logic [31:0]      en;
        logic [31:0]      ovf;
        logic [31:0]      ie;
        logic [SEL_W-1:0] sel;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    logic [31:0]      cnt_w  [NUM_CNT];
    logic [EVT_W-1:0] type_w [NUM_CNT];
    logic [NUM_CNT-1:0] wrap_w;
    logic [63:0]      cyc_w;
    logic             cyc_wrap;
    logic             sel_ok;
    logic [31:0]      wrap_vec;
    logic [31:0]      id0, id1;
    logic             zero_evt, zero_cyc;

    function automatic logic wr_at(input pmu_reg_e ra);
        return wr_en && (addr == ADDR_W'(ra));
    endfunction

    assign sel_ok   = (st_q.sel < SEL_LIM);
    assign zero_evt = wr_at(RA_CTRL) && wdata[CTRL_ZEVT];
    assign zero_cyc = wr_at(RA_CTRL) && wdata[CTRL_ZCYC];

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        pmu_evt_cnt #(.NUM_EVT(NUM_EVT), .EVT_W(EVT_W)) u_evt (
            .clk        (clk),
            .rst_n      (rst_n),
            .count_en   (st_q.gen_en && st_q.en[i]),
            .zero       (zero_evt),
            .wr_type    (wr_at(RA_EVTYPE) && sel_ok && (st_q.sel[IDX_W-1:0] == IDX_W'(i))),
            .wr_cnt     (wr_at(RA_EVCNT)  && sel_ok && (st_q.sel[IDX_W-1:0] == IDX_W'(i))),
            .wdata      (wdata),
            .evt_strobe (evt_strobe),
            .cnt_o      (cnt_w[i]),
            .type_o     (type_w[i]),
            .wrap_o     (wrap_w[i])
        );
    end

    pmu_cyc_cnt u_cyc (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (st_q.gen_en && st_q.en[CYC_BIT]),
        .zero     (zero_cyc),
        .wr_lo    (wr_at(RA_CYC_LO)),
        .wr_hi    (wr_at(RA_CYC_HI)),
        .wdata    (wdata),
        .cnt_o    (cyc_w),
        .wrap_o   (cyc_wrap)
    );

    always_comb begin
        wrap_vec = '0;
        wrap_vec[NUM_CNT-1:0] = wrap_w;
        wrap_vec[CYC_BIT]     = cyc_wrap;
        for (int k = 0; k < 32; k++) begin
            id0[k] = (k < NUM_EVT);
            id1[k] = (k + 32 < NUM_EVT);
        end
    end

    // Next state of the control words; a wrap overrides a software clear.
    always_comb begin
        st_d = st_q;
        if (wr_at(RA_CTRL))    st_d.gen_en = wdata[CTRL_GEN];
        if (wr_at(RA_SEL))     st_d.sel    = wdata[SEL_W-1:0];
        if (wr_at(RA_EN_SET))  st_d.en     = st_q.en | (wdata & LIVE_MASK);
        if (wr_at(RA_EN_CLR))  st_d.en     = st_q.en & ~wdata;
        if (wr_at(RA_IE_SET))  st_d.ie     = st_q.ie | (wdata & LIVE_MASK);
        if (wr_at(RA_IE_CLR))  st_d.ie     = st_q.ie & ~wdata;
        if (wr_at(RA_OVF_SET)) st_d.ovf    = st_q.ovf | (wdata & LIVE_MASK);
        if (wr_at(RA_OVF_CLR)) st_d.ovf    = st_q.ovf & ~wdata;
        st_d.ovf = st_d.ovf | wrap_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(RA_CTRL):    rdata[CTRL_GEN] = st_q.gen_en;
            ADDR_W'(RA_EN_SET),
            ADDR_W'(RA_EN_CLR):  rdata = st_q.en;
            ADDR_W'(RA_OVF_SET),
            ADDR_W'(RA_OVF_CLR): rdata = st_q.ovf;
            ADDR_W'(RA_IE_SET),
            ADDR_W'(RA_IE_CLR):  rdata = st_q.ie;
            ADDR_W'(RA_SEL):     rdata[SEL_W-1:0] = st_q.sel;
            ADDR_W'(RA_EVTYPE):  if (sel_ok) rdata[EVT_W-1:0] = type_w[st_q.sel[IDX_W-1:0]];
            ADDR_W'(RA_EVCNT):   if (sel_ok) rdata = cnt_w[st_q.sel[IDX_W-1:0]];
            ADDR_W'(RA_CYC_LO):  rdata = cyc_w[31:0];
            ADDR_W'(RA_CYC_HI):  rdata = cyc_w[63:32];
            ADDR_W'(RA_ID0):     rdata = id0;
            ADDR_W'(RA_ID1):     rdata = id1;
            default:             rdata = '0;
        endcase
    end

    assign irq = |(st_q.ovf & st_q.ie);

endmodule

// File: rtl/clust_pmu_chk.sv
module clust_pmu_chk
    import clust_pmu_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              wdata0,
    input logic              irq,
    input logic              gen_en,
    input logic [31:0]       en_q,
    input logic [31:0]       ovf_q,
    input logic [31:0]       cnt0
);
    AST_EN_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(RA_EN_SET) && wdata0) |=> en_q[0]); // R3

    AST_EN_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(RA_EN_CLR) && wdata0) |=> !en_q[0]); // R3

    AST_OVF_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(RA_OVF_SET) && wdata0) |=> ovf_q[0]); // R5

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q[0] && !(wr_en && addr == ADDR_W'(RA_OVF_CLR) && wdata0)) |=> ovf_q[0]); // R5

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ovf_q != 32'd0)); // R6

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_en && !wr_en) |=> $stable(cnt0)); // R2

endmodule

bind clust_pmu clust_pmu_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata0 (wdata[0]),
    .irq    (irq),
    .gen_en (st_q.gen_en),
    .en_q   (st_q.en),
    .ovf_q  (st_q.ovf),
    .cnt0   (cnt_w[0])
);

// File: tb/clust_pmu_tb.sv
module clust_pmu_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCNT = 4;
    localparam int NEVT = 16;
    localparam logic [31:0] LIVE = 32'h8000_000F;

    localparam logic [3:0] A_CTRL = 4'd0, A_ENS = 4'd1, A_ENC = 4'd2,
        A_OVS = 4'd3, A_OVC = 4'd4, A_IES = 4'd5, A_IEC = 4'd6, A_SEL = 4'd7,
        A_TYP = 4'd8, A_CNT = 4'd9, A_CLO = 4'd10, A_CHI = 4'd11,
        A_ID0 = 4'd12, A_ID1 = 4'd13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [NEVT-1:0] strobe = '0;
    logic [31:0] rdata;
    logic        irq;

    int vectors = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clust_pmu #(.NUM_CNT(NCNT), .NUM_EVT(NEVT)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .evt_strobe(strobe), .irq(irq)
    );

    // Behavioural reference model
    logic [31:0] m_en, m_ovf, m_ie;
    logic        m_gen;
    int          m_sel;
    int          m_typ [NCNT];
    logic [31:0] m_cnt [NCNT];
    logic [63:0] m_cyc;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_ovf = 0; m_ie = 0; m_gen = 0; m_sel = 0; m_cyc = 0;
            for (int n = 0; n < NCNT; n++) begin m_typ[n] = 0; m_cnt[n] = 0; end
        end else begin
            logic [31:0] wraps;
            logic g;
            logic [31:0] en_old;
            wraps = 0; g = m_gen; en_old = m_en;
            for (int n = 0; n < NCNT; n++) begin
                if (wr_en && addr == A_CTRL && wdata[1]) m_cnt[n] = 0;
                else if (wr_en && addr == A_CNT && m_sel == n) m_cnt[n] = wdata;
                else if (g && en_old[n] && m_typ[n] < NEVT && strobe[m_typ[n]]) begin
                    if (m_cnt[n] == 32'hFFFF_FFFF) wraps[n] = 1'b1;
                    m_cnt[n] = m_cnt[n] + 1;
                end
            end
            if (wr_en && addr == A_CTRL && wdata[2]) m_cyc = 0;
            else if (wr_en && addr == A_CLO) m_cyc[31:0] = wdata;
            else if (wr_en && addr == A_CHI) m_cyc[63:32] = wdata;
            else if (g && en_old[31]) begin
                if (m_cyc == 64'hFFFF_FFFF_FFFF_FFFF) wraps[31] = 1'b1;
                m_cyc = m_cyc + 1;
            end
            if (wr_en) begin
                case (addr)
                    A_CTRL: m_gen = wdata[0];
                    A_ENS:  m_en  = m_en | (wdata & LIVE);
                    A_ENC:  m_en  = m_en & ~wdata;
                    A_IES:  m_ie  = m_ie | (wdata & LIVE);
                    A_IEC:  m_ie  = m_ie & ~wdata;
                    A_OVS:  m_ovf = m_ovf | (wdata & LIVE);
                    A_OVC:  m_ovf = m_ovf & ~wdata;
                    A_SEL:  m_sel = int'(wdata[4:0]);
                    A_TYP:  if (m_sel < NCNT) m_typ[m_sel] = int'(wdata[5:0]);
                    default: ;
                endcase
            end
            m_ovf = m_ovf | wraps;
        end
    end

    function automatic logic [31:0] m_read(input logic [3:0] a);
        case (a)
            A_CTRL: return {31'b0, m_gen};
            A_ENS, A_ENC: return m_en;
            A_OVS, A_OVC: return m_ovf;
            A_IES, A_IEC: return m_ie;
            A_SEL: return 32'(m_sel);
            A_TYP: return (m_sel < NCNT) ? 32'(m_typ[m_sel]) : 32'd0;
            A_CNT: return (m_sel < NCNT) ? m_cnt[m_sel] : 32'd0;
            A_CLO: return m_cyc[31:0];
            A_CHI: return m_cyc[63:32];
            A_ID0: return 32'h0000_FFFF;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] a);
        case (a)
            A_CTRL: return "R10";
            A_ENS, A_ENC: return "R3";
            A_OVS, A_OVC: return "R5";
            A_IES, A_IEC: return "R6";
            A_SEL, A_TYP: return "R7";
            A_CNT: return "R2";
            A_CLO, A_CHI: return "R9";
            default: return "R11";
        endcase
    endfunction

    task automatic compare_all();
        if (rst_n) begin
            vectors++;
            if (rdata !== m_read(addr)) begin
                fails++;
                $display("FAIL %s model read addr %0d: got %h expected %h",
                         tag_of(addr), addr, rdata, m_read(addr));
            end
            vectors++;
            if (irq !== |(m_ovf & m_ie)) begin
                fails++;
                $display("FAIL R6 model irq: got %b expected %b", irq, |(m_ovf & m_ie));
            end
        end
    endtask

    task automatic cyc(input logic w, input logic [3:0] a, input logic [31:0] d,
                       input logic [NEVT-1:0] s);
        @(negedge clk);
        compare_all();
        wr_en = w; addr = a; wdata = d; strobe = s;
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, input string tag, input logic [31:0] exp);
        cyc(1'b0, a, 32'd0, '0);
        chk(tag, rdata, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) cyc(1'b0, 4'd0, 0, '0);
        rst_n = 1'b1;
        // R1 reset state
        rd(A_ENS, "R1 enable word", 0);
        rd(A_OVC, "R1 overflow word", 0);
        rd(A_CNT, "R1 counter0", 0);
        rd(A_CLO, "R1 cycle low", 0);
        chk("R1 irq", {31'b0, irq}, 0);
        // R11 identification
        rd(A_ID0, "R11 id0", 32'h0000_FFFF);
        rd(A_ID1, "R11 id1", 0);
        cyc(1'b1, A_ID0, 0, '0);
        rd(A_ID0, "R11 id0 after write", 32'h0000_FFFF);
        // R2 programming and counting
        cyc(1'b1, A_SEL, 0, '0);
        cyc(1'b1, A_TYP, 3, '0);
        cyc(1'b1, A_SEL, 1, '0);
        cyc(1'b1, A_TYP, 20, '0);
        cyc(1'b1, A_ENS, 3, '0);
        cyc(1'b1, A_CTRL, 1, '0);
        repeat (5) cyc(1'b0, A_ID0, 0, 16'hFFFF);
        cyc(1'b0, A_CNT, 0, '0);
        chk("R2 counter1 unimplemented code", rdata, 0);
        cyc(1'b1, A_SEL, 0, '0);
        rd(A_CNT, "R2 counter0 five strobes", 5);
        // R3 enable clear
        cyc(1'b1, A_ENC, 1, '0);
        rd(A_ENS, "R3 enable after clear", 2);
        rd(A_ENC, "R3 enable via clr addr", 2);
        repeat (3) cyc(1'b0, A_ID0, 0, 16'hFFFF);
        rd(A_CNT, "R3 disabled counter holds", 5);
        // R2 global gate
        cyc(1'b1, A_ENS, 1, '0);
        cyc(1'b1, A_CTRL, 0, '0);
        repeat (3) cyc(1'b0, A_ID0, 0, 16'hFFFF);
        rd(A_CNT, "R2 global enable gates", 5);
        cyc(1'b1, A_CTRL, 1, '0);
        // R4 wrap
        cyc(1'b1, A_SEL, 2, '0);
        cyc(1'b1, A_TYP, 5, '0);
        cyc(1'b1, A_CNT, 32'hFFFF_FFFE, '0);
        cyc(1'b1, A_ENS, 4, '0);
        repeat (2) cyc(1'b0, A_ID0, 0, 16'h0020);
        rd(A_CNT, "R4 counter2 wrapped", 0);
        rd(A_OVC, "R4 overflow flag 2", 4);
        chk("R6 irq masked", {31'b0, irq}, 0);
        // R6 interrupt enables
        cyc(1'b1, A_IES, 4, '0);
        rd(A_IES, "R6 ie word", 4);
        chk("R6 irq asserted", {31'b0, irq}, 1);
        cyc(1'b1, A_OVC, 4, '0);
        rd(A_OVC, "R5 flag cleared", 0);
        chk("R6 irq dropped", {31'b0, irq}, 0);
        cyc(1'b1, A_OVS, 1, '0);
        rd(A_OVC, "R5 software set", 1);
        chk("R6 irq needs enable", {31'b0, irq}, 0);
        cyc(1'b1, A_IES, 1, '0);
        cyc(1'b0, A_ID0, 0, '0);
        chk("R6 irq on flag0", {31'b0, irq}, 1);
        cyc(1'b1, A_IEC, 1, '0);
        cyc(1'b0, A_ID0, 0, '0);
        chk("R6 irq after ie clear", {31'b0, irq}, 0);
        cyc(1'b1, A_OVC, 1, '0);
        // R5 wrap against clear in the same cycle
        cyc(1'b1, A_CNT, 32'hFFFF_FFFF, '0);
        cyc(1'b1, A_OVS, 4, '0);
        cyc(1'b1, A_OVC, 4, 16'h0020);
        rd(A_OVC, "R5 wrap beats clear", 4);
        rd(A_CNT, "R5 counter2 wrapped", 0);
        // R8 load against increment
        cyc(1'b1, A_CNT, 100, 16'h0020);
        rd(A_CNT, "R8 write wins", 100);
        cyc(1'b0, A_ID0, 0, 16'h0020);
        rd(A_CNT, "R8 counts after load", 101);
        cyc(1'b1, A_OVC, 4, '0);
        cyc(1'b1, A_IEC, 4, '0);
        // R7 selector out of range
        cyc(1'b1, A_SEL, 7, '0);
        rd(A_CNT, "R7 bad index count", 0);
        rd(A_TYP, "R7 bad index type", 0);
        cyc(1'b1, A_CNT, 55, '0);
        cyc(1'b1, A_TYP, 9, '0);
        cyc(1'b1, A_SEL, 0, '0);
        rd(A_CNT, "R7 counter0 untouched", 5);
        rd(A_TYP, "R7 type0 untouched", 3);
        cyc(1'b1, A_SEL, 2, '0);
        rd(A_CNT, "R7 counter2 untouched", 101);
        // R9 cycle counter
        cyc(1'b1, A_CTRL, 0, '0);
        cyc(1'b1, A_CLO, 32'hFFFF_FFFE, '0);
        cyc(1'b1, A_CHI, 1, '0);
        cyc(1'b1, A_ENS, 32'h8000_0000, '0);
        cyc(1'b1, A_CTRL, 1, '0);
        rd(A_CLO, "R9 low before count", 32'hFFFF_FFFE);
        rd(A_CLO, "R9 low after one", 32'hFFFF_FFFF);
        rd(A_CHI, "R9 carry into high", 2);
        // R4 cycle counter wrap
        cyc(1'b1, A_CTRL, 0, '0);
        cyc(1'b1, A_CLO, 32'hFFFF_FFFF, '0);
        cyc(1'b1, A_CHI, 32'hFFFF_FFFF, '0);
        cyc(1'b1, A_CTRL, 1, '0);
        rd(A_OVC, "R4 no cycle flag yet", 0);
        rd(A_OVC, "R4 cycle flag bit31", 32'h8000_0000);
        rd(A_CHI, "R4 cycle high wrapped", 0);
        // R10 control zeroing
        cyc(1'b1, A_OVC, 32'h8000_0000, '0);
        cyc(1'b1, A_CTRL, 32'h6, '0);
        rd(A_CTRL, "R10 global off", 0);
        rd(A_CNT, "R10 event zeroed", 0);
        rd(A_CLO, "R10 cycle zeroed", 0);
        cyc(1'b1, A_CTRL, 1, '0);
        cyc(1'b1, A_SEL, 0, '0);
        cyc(1'b1, A_CNT, 7, '0);
        cyc(1'b1, A_CTRL, 3, 16'h0008);
        rd(A_CNT, "R10 zero beats count", 0);
        rd(A_CTRL, "R10 action bits read 0", 1);
        cyc(1'b0, A_ID0, 0, '0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule